// File: doc/BRIEF.md
# Register Rename Map

This block is the rename map of an out-of-order core. For every architectural register it holds one small map entry that says where the newest value of that register will come from. The value either already sits in the architectural register file, or it is still being produced and will appear in a given reorder buffer slot. Issue logic presents up to `LANES` instructions per cycle, listed from oldest (lane 0) to youngest. Each instruction has two source registers, and the map returns the location of each source within the same cycle. For each instruction that receives a reorder buffer slot, the issue logic also sends the destination register and the slot number.

Each map entry is a two-state machine. In `MAP_ARCH` the register is served by the register file. In `MAP_ROB` it waits on the slot held in the entry's tag. The transitions are named as follows. ALLOCATE moves an entry from `MAP_ARCH` to `MAP_ROB` when an instruction names the register as its destination. RETARGET keeps the entry in `MAP_ROB` and loads a newer slot. RETIRE moves the entry back to `MAP_ARCH` when the reorder buffer commits the slot the entry still holds. FLUSH moves every entry to `MAP_ARCH` at once. If several of these arrive in one cycle, FLUSH wins, then ALLOCATE/RETARGET, then RETIRE.

Lookups see the map as it stands at the start of the cycle. Three things that happen in the same cycle adjust the answer: a write from an older lane of the same issue group, a commit that matches the entry, and a flush.

Top module: `rename_map`

## Requirements
- R1: After reset, every register maps to the register file, and every lookup returns `src_in_rob`=0 and `src_tag`=0.
- R2: A lookup of a register in `MAP_ROB` returns `src_in_rob`=1 and the stored slot. A lookup of a register in `MAP_ARCH` returns `src_in_rob`=0 and `src_tag`=0. In `src_in_rob`, 1 means reorder buffer and 0 means register file.
- R3: An allocation on lane L maps register `alloc_dst[L*AW +: AW]` to slot `alloc_tag[L*TW +: TW]` from the next cycle on. When several lanes in one group write the same register, the highest-numbered (youngest) lane wins.
- R4: A mapping stays unchanged until a later allocation overwrites it (RETARGET), a matching commit clears it, or a flush occurs.
- R5: The source of lane L that names a register written by an older lane i<L in the same cycle gets the tag of the youngest such lane, with `src_in_rob`=1. Source s of lane L is at index L*2+s in the source vectors.
- R6: A commit whose `commit_tag` equals the slot stored for `commit_reg` returns that register to the register file on the next cycle.
- R7: A commit whose tag differs from the stored slot, or that names a register in `MAP_ARCH`, leaves the mapping unchanged.
- R8: During a cycle with a matching commit, lookups of that register report the register file, unless an older lane in the group rewrites it.
- R9: An allocation and a matching commit for the same register in one cycle leave the register mapped to the new slot.
- R10: While `flush` is high, every lookup reports the register file and allocations and commits are ignored. On the next cycle every register maps to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Return all registers to the register file |
| alloc_valid | input | LANES | Lane L allocates a slot this cycle |
| alloc_dst | input | LANES*AW | Destination register per lane |
| alloc_tag | input | LANES*TW | Reorder buffer slot given to each lane |
| commit_valid | input | 1 | A slot commits this cycle |
| commit_reg | input | AW | Destination register of the committing slot |
| commit_tag | input | TW | Committing slot number |
| src_reg | input | LANES*2*AW | Source register per lane and operand |
| src_in_rob | output | LANES*2 | 1 when the source is waiting on a reorder buffer slot |
| src_tag | output | LANES*2*TW | Slot the source waits on, 0 otherwise |

## Verification
Some properties are checked on every cycle: a flush empties the map and silences lookups, the youngest lane's write lands, a matching commit clears the entry, a mismatched commit keeps it, and an idle cycle disturbs nothing. The combinational answers need the bench's scenarios. These include the older-lane bypass within a group, forwarding of a same-cycle commit into lookups, and an allocation colliding with a commit on the same register. Each of these is compared against a behavioural model on every cycle of directed and pseudo-random traffic.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    typedef enum logic {
        MAP_ARCH = 1'b0,
        MAP_ROB  = 1'b1
    } map_state_e;
endpackage

// File: rtl/rmap_entry.sv
module rmap_entry
    import rmap_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          set_en,
    input  logic [TW-1:0] set_tag,
    input  logic          clr_en,
    input  logic [TW-1:0] clr_tag,
    output logic          in_rob,
    output logic [TW-1:0] tag
);
    map_state_e    state_q, state_d;
    logic [TW-1:0] tag_q, tag_d;

    // next-state: FLUSH > ALLOCATE/RETARGET > RETIRE
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            MAP_ARCH: begin
                if (!flush && set_en) begin
                    state_d = MAP_ROB;
                    tag_d   = set_tag;
                end
            end
            MAP_ROB: begin
                if (flush) begin
                    state_d = MAP_ARCH;
                    tag_d   = '0;
                end else if (set_en) begin
                    tag_d   = set_tag;
                end else if (clr_en && (clr_tag == tag_q)) begin
                    state_d = MAP_ARCH;
                    tag_d   = '0;
                end
            end
            default: begin
                state_d = MAP_ARCH;
                tag_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MAP_ARCH;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    always_comb begin
        in_rob = (state_q == MAP_ROB);
        tag    = tag_q;
    end
endmodule

// File: rtl/rmap_lookup.sv
module rmap_lookup #(
    parameter int REGS  = 8,
    parameter int AW    = 3,
    parameter int TW    = 4,
    parameter int LANES = 2,
    parameter int LANE  = 0
) (
    input  logic [AW-1:0]       src_reg,
    input  logic [REGS-1:0]     table_rob,
    input  logic [REGS*TW-1:0]  table_tag,
    input  logic                flush,
    input  logic                commit_valid,
    input  logic [AW-1:0]       commit_reg,
    input  logic [TW-1:0]       commit_tag,
    input  logic [LANES-1:0]    alloc_valid,
    input  logic [LANES*AW-1:0] alloc_dst,
    input  logic [LANES*TW-1:0] alloc_tag,
    output logic                in_rob,
    output logic [TW-1:0]       tag
);
    logic          hit_rob;
    logic [TW-1:0] hit_tag;

    always_comb begin
        hit_rob = table_rob[src_reg];
        hit_tag = table_tag[int'(src_reg)*TW +: TW];
        if (commit_valid && (commit_reg == src_reg) && (commit_tag == hit_tag))
            hit_rob = 1'b0;
        // older lanes of this group, youngest last so it wins
        for (int i = 0; i < LANE; i++) begin
            if (alloc_valid[i] && (alloc_dst[i*AW +: AW] == src_reg)) begin
                hit_rob = 1'b1;
                hit_tag = alloc_tag[i*TW +: TW];
            end
        end
        if (flush)
            hit_rob = 1'b0;
        in_rob = hit_rob;
        tag    = hit_rob ? hit_tag : '0;
    end
endmodule

// File: rtl/rename_map.sv
module rename_map #(
    parameter int ARCH_REGS   = 8,
    parameter int ROB_ENTRIES = 16,
    parameter int LANES       = 2,
    localparam int AW   = $clog2(ARCH_REGS),
    localparam int TW   = $clog2(ROB_ENTRIES),
    localparam int SRCS = 2,
    localparam int NSRC = LANES * SRCS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [LANES-1:0]    alloc_valid,
    input  logic [LANES*AW-1:0] alloc_dst,
    input  logic [LANES*TW-1:0] alloc_tag,
    input  logic                commit_valid,
    input  logic [AW-1:0]       commit_reg,
    input  logic [TW-1:0]       commit_tag,
    input  logic [NSRC*AW-1:0]  src_reg,
    output logic [NSRC-1:0]     src_in_rob,
    output logic [NSRC*TW-1:0]  src_tag
);
    logic [ARCH_REGS-1:0]    table_rob;
    logic [ARCH_REGS*TW-1:0] table_tag;

    for (genvar r = 0; r < ARCH_REGS; r++) begin : g_reg
        logic          sel;
        logic [TW-1:0] sel_tag;
        logic          clr;

        always_comb begin
            sel     = 1'b0;
            sel_tag = '0;
            for (int l = 0; l < LANES; l++) begin
                if (alloc_valid[l] && (alloc_dst[l*AW +: AW] == AW'(r))) begin
                    sel     = 1'b1;
                    sel_tag = alloc_tag[l*TW +: TW];
                end
            end
            clr = commit_valid && (commit_reg == AW'(r));
        end

        rmap_entry #(.TW(TW)) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .set_en  (sel),
            .set_tag (sel_tag),
            .clr_en  (clr),
            .clr_tag (commit_tag),
            .in_rob  (table_rob[r]),
            .tag     (table_tag[r*TW +: TW])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar s = 0; s < SRCS; s++) begin : g_src
            localparam int IDX = l * SRCS + s;
            rmap_lookup #(
                .REGS  (ARCH_REGS),
                .AW    (AW),
                .TW    (TW),
                .LANES (LANES),
                .LANE  (l)
            ) u_lookup (
                .src_reg      (src_reg[IDX*AW +: AW]),
                .table_rob    (table_rob),
                .table_tag    (table_tag),
                .flush        (flush),
                .commit_valid (commit_valid),
                .commit_reg   (commit_reg),
                .commit_tag   (commit_tag),
                .alloc_valid  (alloc_valid),
                .alloc_dst    (alloc_dst),
                .alloc_tag    (alloc_tag),
                .in_rob       (src_in_rob[IDX]),
                .tag          (src_tag[IDX*TW +: TW])
            );
        end
    end
endmodule

// File: rtl/rename_map_checker.sv
module rename_map_checker #(
    parameter int ARCH_REGS   = 8,
    parameter int ROB_ENTRIES = 16,
    parameter int LANES       = 2,
    localparam int AW   = $clog2(ARCH_REGS),
    localparam int TW   = $clog2(ROB_ENTRIES),
    localparam int NSRC = LANES * 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    flush,
    input logic [LANES-1:0]        alloc_valid,
    input logic [LANES*AW-1:0]     alloc_dst,
    input logic [LANES*TW-1:0]     alloc_tag,
    input logic                    commit_valid,
    input logic [AW-1:0]           commit_reg,
    input logic [TW-1:0]           commit_tag,
    input logic [NSRC-1:0]         src_in_rob,
    input logic [ARCH_REGS-1:0]    table_rob,
    input logic [ARCH_REGS*TW-1:0] table_tag
);
    logic          cm_touch;
    logic [TW-1:0] cm_cur;
    logic          young_q, hit_q, miss_q;
    logic [AW-1:0] young_dst_q, cm_reg_q;
    logic [TW-1:0] young_tag_q, miss_tag_q;

    always_comb begin
        cm_touch = 1'b0;
        for (int l = 0; l < LANES; l++)
            if (alloc_valid[l] && (alloc_dst[l*AW +: AW] == commit_reg))
                cm_touch = 1'b1;
        cm_cur = table_tag[int'(commit_reg)*TW +: TW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            young_q     <= 1'b0;
            hit_q       <= 1'b0;
            miss_q      <= 1'b0;
            young_dst_q <= '0;
            young_tag_q <= '0;
            cm_reg_q    <= '0;
            miss_tag_q  <= '0;
        end else begin
            young_q     <= alloc_valid[LANES-1] && !flush;
            young_dst_q <= alloc_dst[(LANES-1)*AW +: AW];
            young_tag_q <= alloc_tag[(LANES-1)*TW +: TW];
            hit_q       <= commit_valid && !flush && !cm_touch &&
                           table_rob[commit_reg] && (cm_cur == commit_tag);
            miss_q      <= commit_valid && !flush && !cm_touch &&
                           table_rob[commit_reg] && (cm_cur != commit_tag);
            cm_reg_q    <= commit_reg;
            miss_tag_q  <= cm_cur;
        end
    end

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (table_rob == '0));

    assert_flush_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (src_in_rob == '0));

    assert_youngest_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        young_q |-> (table_rob[young_dst_q] &&
                     table_tag[int'(young_dst_q)*TW +: TW] == young_tag_q));

    assert_commit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> !table_rob[cm_reg_q]);

    assert_commit_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> (table_rob[cm_reg_q] &&
                    table_tag[int'(cm_reg_q)*TW +: TW] == miss_tag_q));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && alloc_valid == '0 && !commit_valid) |=>
            ($stable(table_rob) && $stable(table_tag)));
endmodule

bind rename_map rename_map_checker #(
    .ARCH_REGS   (ARCH_REGS),
    .ROB_ENTRIES (ROB_ENTRIES),
    .LANES       (LANES)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .alloc_valid  (alloc_valid),
    .alloc_dst    (alloc_dst),
    .alloc_tag    (alloc_tag),
    .commit_valid (commit_valid),
    .commit_reg   (commit_reg),
    .commit_tag   (commit_tag),
    .src_in_rob   (src_in_rob),
    .table_rob    (table_rob),
    .table_tag    (table_tag)
);

// File: tb/rename_map_bench.sv
module rename_map_bench;
    localparam int REGS  = 8;
    localparam int ROBS  = 16;
    localparam int LANES = 2;
    localparam int AW    = $clog2(REGS);
    localparam int TW    = $clog2(ROBS);
    localparam int NSRC  = LANES * 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                flush = 1'b0;
    logic [LANES-1:0]    alloc_valid = '0;
    logic [LANES*AW-1:0] alloc_dst = '0;
    logic [LANES*TW-1:0] alloc_tag = '0;
    logic                commit_valid = 1'b0;
    logic [AW-1:0]       commit_reg = '0;
    logic [TW-1:0]       commit_tag = '0;
    logic [NSRC*AW-1:0]  src_reg = '0;
    logic [NSRC-1:0]     src_in_rob;
    logic [NSRC*TW-1:0]  src_tag;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural model
    bit mdl_rob [REGS];
    int mdl_tag [REGS];

    rename_map #(.ARCH_REGS(REGS), .ROB_ENTRIES(ROBS), .LANES(LANES)) u_rename_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .alloc_valid  (alloc_valid),
        .alloc_dst    (alloc_dst),
        .alloc_tag    (alloc_tag),
        .commit_valid (commit_valid),
        .commit_reg   (commit_reg),
        .commit_tag   (commit_tag),
        .src_reg      (src_reg),
        .src_in_rob   (src_in_rob),
        .src_tag      (src_tag)
    );

    always #4 clk = ~clk;

    task automatic model_reset();
        for (int r = 0; r < REGS; r++) begin
            mdl_rob[r] = 1'b0;
            mdl_tag[r] = 0;
        end
    endtask

    task automatic clear_inputs();
        flush        = 1'b0;
        alloc_valid  = '0;
        commit_valid = 1'b0;
    endtask

    task automatic set_alloc(int lane, int dst, int tg);
        alloc_valid[lane]           = 1'b1;
        alloc_dst[lane*AW +: AW]    = AW'(dst);
        alloc_tag[lane*TW +: TW]    = TW'(tg);
    endtask

    task automatic set_src(int idx, int r);
        src_reg[idx*AW +: AW] = AW'(r);
    endtask

    task automatic set_commit(int r, int tg);
        commit_valid = 1'b1;
        commit_reg   = AW'(r);
        commit_tag   = TW'(tg);
    endtask

    // compare one cycle (called at negedge after inputs settle), then advance model
    task automatic cycle();
        #1;
        for (int idx = 0; idx < NSRC; idx++) begin
            int    r    = int'(src_reg[idx*AW +: AW]);
            int    lane = idx / 2;
            bit    e_in = mdl_rob[r];
            int    e_tg = mdl_tag[r];
            string req  = cur_req;
            int    a_tg = int'(src_tag[idx*TW +: TW]);
            if (commit_valid && int'(commit_reg) == r && int'(commit_tag) == e_tg && e_in) begin
                e_in = 1'b0;
                req  = "R8";
            end
            for (int i = 0; i < lane; i++) begin
                if (alloc_valid[i] && int'(alloc_dst[i*AW +: AW]) == r) begin
                    e_in = 1'b1;
                    e_tg = int'(alloc_tag[i*TW +: TW]);
                    req  = "R5";
                end
            end
            if (flush) begin
                e_in = 1'b0;
                req  = "R10";
            end
            if (!e_in) e_tg = 0;
            compared++;
            if (src_in_rob[idx] !== e_in || a_tg != e_tg) begin
                mismatched++;
                $display("FAIL %s src%0d reg%0d: actual in_rob=%0b tag=%0d expected in_rob=%0b tag=%0d",
                         req, idx, r, src_in_rob[idx], a_tg, e_in, e_tg);
            end
        end
        if (flush) begin
            model_reset();
        end else begin
            if (commit_valid && mdl_rob[commit_reg] && mdl_tag[commit_reg] == int'(commit_tag)) begin
                mdl_rob[commit_reg] = 1'b0;
                mdl_tag[commit_reg] = 0;
            end
            for (int l = 0; l < LANES; l++) begin
                if (alloc_valid[l]) begin
                    mdl_rob[alloc_dst[l*AW +: AW]] = 1'b1;
                    mdl_tag[alloc_dst[l*AW +: AW]] = int'(alloc_tag[l*TW +: TW]);
                end
            end
        end
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic look4(int a, int b, int c, int d);
        set_src(0, a); set_src(1, b); set_src(2, c); set_src(3, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads as register file after reset
        cur_req = "R1";
        look4(0, 1, 2, 3); cycle();
        look4(4, 5, 6, 7); cycle();

        // R3: lane 0 maps r2 to slot 5; then both lanes write r3, youngest wins
        cur_req = "R3";
        set_alloc(0, 2, 5); look4(2, 2, 1, 1); cycle();
        look4(2, 0, 2, 3); cycle();
        set_alloc(0, 3, 6); set_alloc(1, 3, 7); look4(3, 3, 0, 0); cycle();
        look4(3, 2, 3, 2); cycle();

        // R4: later writer overwrites; idle holds the mapping
        cur_req = "R4";
        set_alloc(1, 2, 9); cycle();
        look4(2, 3, 2, 3); cycle();
        look4(2, 3, 2, 3); cycle();

        // R5: lane 1 sees lane 0's fresh slot for r4 in the same cycle
        cur_req = "R5";
        set_alloc(0, 4, 10); look4(4, 4, 4, 2); cycle();
        look4(4, 4, 4, 4); cycle();

        // R6: matching commit returns r4 to the register file
        cur_req = "R6";
        set_commit(4, 10); cycle();
        look4(4, 4, 4, 4); cycle();

        // R7: stale commit of r2 (slot 5) keeps slot 9; commit of an arch register is ignored
        cur_req = "R7";
        set_commit(2, 5); look4(2, 2, 2, 2); cycle();
        set_commit(5, 0); cycle();
        look4(2, 5, 2, 5); cycle();

        // R8: matching commit is seen by lookups in the same cycle
        cur_req = "R8";
        set_commit(2, 9); look4(2, 2, 2, 2); cycle();
        look4(2, 2, 2, 2); cycle();

        // R9: allocation and matching commit of r3 together leave new slot
        cur_req = "R9";
        set_commit(3, 7); set_alloc(0, 3, 11); look4(3, 3, 3, 3); cycle();
        look4(3, 3, 3, 3); cycle();

        // R10: flush silences lookups, drops allocations, empties the map
        cur_req = "R10";
        set_alloc(0, 6, 12); cycle();
        flush = 1'b1; set_alloc(0, 1, 13); set_alloc(1, 6, 14); set_commit(3, 11);
        look4(6, 3, 1, 6); cycle();
        look4(6, 3, 1, 0); cycle();
        look4(4, 5, 6, 7); cycle();

        // R2: pseudo-random traffic against the model
        cur_req = "R2";
        for (int n = 0; n < 3000; n++) begin
            for (int l = 0; l < LANES; l++)
                if ($urandom_range(0, 2) != 0) set_alloc(l, $urandom_range(0, REGS-1), $urandom_range(0, ROBS-1));
            if ($urandom_range(0, 1) != 0) begin
                int cr = $urandom_range(0, REGS-1);
                set_commit(cr, ($urandom_range(0, 3) != 0) ? mdl_tag[cr] : $urandom_range(0, ROBS-1));
            end
            flush = ($urandom_range(0, 63) == 0);
            for (int s = 0; s < NSRC; s++) set_src(s, $urandom_range(0, REGS-1));
            cycle();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule